// File: doc/BRIEF.md
# Snooping Page Mapper

This block gives a 6502-style 8-bit processor four 256-byte address windows, each of which can be pointed at any 256-byte-aligned page of an external RAM or an external flash. The CPU does not write a control register to select a page. The block watches the bus instead. Any bus cycle, read or write, that touches one of eight reserved zero-page addresses loads the byte on the data bus into the page register of one window. The reserved address that was touched also sets whether that window maps to RAM or to flash.

The windows sit next to each other at $7C00, $7D00, $7E00 and $7F00. Software can place consecutive pages in neighbouring windows, so that a record that crosses a page boundary stays contiguous in the CPU's view. Inside a window the low eight CPU address bits pass through unchanged and the window's page register supplies the upper eight bits of the backing-memory offset. Each bus cycle is taken to end at the rising edge of `clk`, and a snooped byte is captured there.

Top module: `page_mapper`

## Requirements
- R1: After reset every window holds page 0 with RAM selected, so an access to $7C34 gives ext_addr $0034 with ram_sel high.
- R2: A bus cycle at address $00FC+k (k = 0..3) loads the data byte into the page register of window k and marks that window as RAM, starting with the next bus cycle.
- R3: A bus cycle at address $00F8+k (k = 0..3) loads the data byte into the page register of window k and marks that window as flash, starting with the next bus cycle.
- R4: A load changes only the addressed window. Two back-to-back loads into different windows leave two independent pages, and the other windows keep their previous contents.
- R5: An access at address $7C00 + 256*k + n (n = 0..255) drives win_hit high and ext_addr = {page of window k, n}. It raises exactly one of ram_sel (window marked RAM) or flash_sel (window marked flash).
- R6: An access outside $7C00-$7FFF drives win_hit, ram_sel and flash_sel low and ext_addr to zero.
- R7: Addresses near the reserved ones, such as $00F7, $01FC or $80FC, load no window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; its rising edge ends a bus cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address of the current bus cycle |
| cpu_data | input | 8 | Data bus byte of the current bus cycle |
| ext_addr | output | 16 | Backing-memory offset: window page and low address byte |
| ram_sel | output | 1 | External RAM select |
| flash_sel | output | 1 | External flash select |
| win_hit | output | 1 | The current address falls in one of the windows |

## Verification
Translation is combinational, so ext_addr, win_hit and both selects are due in the same bus cycle as the address that produces them. A snoop takes effect one bus cycle later, because the page register updates at the edge that ends the snooped cycle. The bench drives each cycle's address and data just after the falling clock edge and samples 1 ns later, well before the capturing rising edge. It applies a snoop to its own page model only after that sample, so the model's view of each page matches the design's in every cycle. The back-to-back loads into windows 0 and 1 are checked on the very next cycles.

// File: rtl/pmap_pkg.sv
package pmap_pkg;
  localparam int PAGE_W = 8;
  localparam int OFF_W  = 8;
  localparam int ADDR_W = 16;
  localparam int NUM_WIN = 4;
  localparam int WIN_W  = $clog2(NUM_WIN);
  localparam int EXT_W  = PAGE_W + OFF_W;
  localparam logic [ADDR_W-1:0] WIN_BASE   = 16'h7C00;
  localparam logic [ADDR_W-1:0] SNOOP_BASE = 16'h00F8; // flash group; RAM group follows

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic              is_flash;
  } win_reg_t;

  typedef struct packed {
    logic             hit;
    logic             is_flash;
    logic [WIN_W-1:0] idx;
  } snoop_t;

  // Classify an address as a page-load snoop.
  function automatic snoop_t decode_snoop(input logic [ADDR_W-1:0] a);
    snoop_t s;
    s.hit      = (a >> (WIN_W + 1)) == (SNOOP_BASE >> (WIN_W + 1));
    s.is_flash = ~a[WIN_W];
    s.idx      = a[WIN_W-1:0];
    return s;
  endfunction

  function automatic logic in_window(input logic [ADDR_W-1:0] a);
    return (a >> (OFF_W + WIN_W)) == (WIN_BASE >> (OFF_W + WIN_W));
  endfunction

  function automatic logic [WIN_W-1:0] window_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: WIN_W];
  endfunction

  function automatic logic [EXT_W-1:0] xlate(input logic [PAGE_W-1:0] pg,
                                             input logic [ADDR_W-1:0] a);
    return {pg, a[OFF_W-1:0]};
  endfunction
endpackage

// File: rtl/pmap_snoop_dec.sv
module pmap_snoop_dec
  import pmap_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr,
  input  logic [PAGE_W-1:0]  data,
  output logic [NUM_WIN-1:0] load_en,
  output logic               load_flash,
  output logic [PAGE_W-1:0]  load_page
);
  snoop_t sn;

  always_comb begin
    sn         = decode_snoop(addr);
    load_en    = '0;
    if (sn.hit) load_en[sn.idx] = 1'b1;
    load_flash = sn.is_flash;
    load_page  = data;
  end
endmodule

// File: rtl/pmap_win_regs.sv
module pmap_win_regs
  import pmap_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_WIN-1:0]          load_en,
  input  logic                        load_flash,
  input  logic [PAGE_W-1:0]           load_page,
  output win_reg_t [NUM_WIN-1:0]      regs
);
  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs[i] <= '0;
      end else if (load_en[i]) begin
        regs[i].page     <= load_page;
        regs[i].is_flash <= load_flash;
      end
    end

    // R2
    ram_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en[i] && !load_flash) |=>
        (regs[i].page == $past(load_page)) && !regs[i].is_flash);

    // R3
    flash_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en[i] && load_flash) |=>
        (regs[i].page == $past(load_page)) && regs[i].is_flash);

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en[i] |=> $stable(regs[i]));
  end
endmodule

// File: rtl/pmap_xlate.sv
module pmap_xlate
  import pmap_pkg::*;
(
  input  logic [ADDR_W-1:0]      addr,
  input  win_reg_t [NUM_WIN-1:0] regs,
  output logic                   hit,
  output logic                   ram_sel,
  output logic                   flash_sel,
  output logic [EXT_W-1:0]       ext_addr
);
  win_reg_t sel;

  always_comb begin
    hit       = in_window(addr);
    sel       = regs[window_of(addr)];
    ram_sel   = hit & ~sel.is_flash;
    flash_sel = hit &  sel.is_flash;
    ext_addr  = hit ? xlate(sel.page, addr) : '0;
  end
endmodule

// File: rtl/page_mapper.sv
module page_mapper
  import pmap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_data,
  output logic [15:0] ext_addr,
  output logic        ram_sel,
  output logic        flash_sel,
  output logic        win_hit
);
  logic [NUM_WIN-1:0]     load_en;
  logic                   load_flash;
  logic [PAGE_W-1:0]      load_page;
  win_reg_t [NUM_WIN-1:0] regs;

  pmap_snoop_dec u_dec (
    .addr      (cpu_addr),
    .data      (cpu_data),
    .load_en   (load_en),
    .load_flash(load_flash),
    .load_page (load_page)
  );

  pmap_win_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_flash(load_flash),
    .load_page (load_page),
    .regs      (regs)
  );

  pmap_xlate u_xlate (
    .addr     (cpu_addr),
    .regs     (regs),
    .hit      (win_hit),
    .ram_sel  (ram_sel),
    .flash_sel(flash_sel),
    .ext_addr (ext_addr)
  );

  // R5
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> (ext_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]) && (ram_sel != flash_sel));

  // R6
  idle_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |-> !ram_sel && !flash_sel && (ext_addr == '0));

  // R5
  sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_sel, flash_sel}));

  // R7
  snoop_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|load_en) |-> (cpu_addr[15:8] == 8'h00) && !win_hit);
endmodule

// File: tb/page_mapper_tb_top.sv
module page_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic [15:0] ext_addr;
  logic        ram_sel, flash_sel, win_hit;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] m_page [4];
  logic       m_flash [4];

  always #2.5 clk = ~clk;

  page_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .ext_addr(ext_addr), .ram_sel(ram_sel), .flash_sel(flash_sel), .win_hit(win_hit)
  );

  // Expected output bundle {ext_addr, win_hit, ram_sel, flash_sel}
  function automatic logic [18:0] expect_out(input logic [15:0] a);
    int w;
    if (a < 16'h7C00 || a > 16'h7FFF) return '0;
    w = (a - 16'h7C00) / 256;
    return {m_page[w], a[7:0], 1'b1, !m_flash[w], m_flash[w]};
  endfunction

  task automatic model_update(input logic [15:0] a, input logic [7:0] d);
    if (a >= 16'h00F8 && a <= 16'h00FF) begin
      m_page[a % 4]  = d;
      m_flash[a % 4] = (a < 16'h00FC);
    end
  endtask

  task automatic bus(input logic [15:0] a, input logic [7:0] d, input string req);
    logic [18:0] exp_v, act_v;
    @(negedge clk);
    cpu_addr = a;
    cpu_data = d;
    #1;
    exp_v = expect_out(a);
    act_v = {ext_addr, win_hit, ram_sel, flash_sel};
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s addr=%h actual={ext=%h hit=%b ram=%b fl=%b} expected={ext=%h hit=%b ram=%b fl=%b}",
               req, a, act_v[18:3], act_v[2], act_v[1], act_v[0],
               exp_v[18:3], exp_v[2], exp_v[1], exp_v[0]);
    end
    model_update(a, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] a;
    int sel;
    for (int i = 0; i < 4; i++) begin m_page[i] = 8'h00; m_flash[i] = 1'b0; end
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state, page 0 RAM in every window
    bus(16'h7C34, 8'h99, "R1");
    bus(16'h7DFF, 8'h00, "R1");
    bus(16'h7F00, 8'h00, "R1");
    // R2: RAM load, visible on the next cycle
    bus(16'h00FC, 8'h5A, "R2");
    bus(16'h7C10, 8'h00, "R2");
    // R4: back-to-back loads into windows 0 and 1, record across boundary
    bus(16'h00FC, 8'h40, "R4");
    bus(16'h00FD, 8'h41, "R4");
    bus(16'h7CFF, 8'h00, "R4");
    bus(16'h7D00, 8'h00, "R4");
    bus(16'h7E80, 8'h00, "R4");
    // R3: flash load
    bus(16'h00F9, 8'hC3, "R3");
    bus(16'h7D80, 8'h00, "R3");
    bus(16'h00FB, 8'hFF, "R3");
    bus(16'h7FFF, 8'h00, "R3");
    // R5: top page, RAM window beside flash window
    bus(16'h00FE, 8'hFF, "R5");
    bus(16'h7EFF, 8'h00, "R5");
    bus(16'h7C00, 8'h00, "R5");
    // R7: nearby addresses load nothing
    bus(16'h00F7, 8'h11, "R7");
    bus(16'h01FC, 8'h22, "R7");
    bus(16'h80FC, 8'h33, "R7");
    bus(16'h00F0, 8'h44, "R7");
    for (int k = 0; k < 4; k++) bus(16'h7C00 + 16'(k * 256) + 16'h0012, 8'h00, "R7");
    // R6: outside the windows
    bus(16'h0000, 8'h00, "R6");
    bus(16'h7BFF, 8'h00, "R6");
    bus(16'h8000, 8'h00, "R6");
    bus(16'hFFFF, 8'h00, "R6");

    // R5: constrained random mix of snoops, window accesses and other traffic
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 4000; i++) begin
      sel = $urandom_range(0, 9);
      if (sel < 3)      a = 16'h00F8 + 16'($urandom_range(0, 7));
      else if (sel < 8) a = 16'h7C00 + 16'($urandom_range(0, 1023));
      else              a = 16'($urandom);
      bus(a, 8'($urandom), "R5");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule